// File: doc/BRIEF.md
# SAR Conversion and Comparison Sequencer

This block controls one successive-approximation operation of a 12-bit converter. On request it powers the converter and waits out a programmable settling time measured in microsecond ticks. It then steps a fixed 15-period schedule on a divided conversion clock. In conversion mode it resolves a code one bit per period, most significant bit first, against an external comparator. In comparison mode it presents a stored threshold to the DAC and records which side of it the input lies on.

When the operation finishes, the block writes the outcome back to the register file through one-cycle write strobes. It asks the register file to drop its enable and start bits, and it raises an end-of-operation flag for one conversion-clock period. A successive option keeps the converter powered between operations, so that only the first one after power-up pays the settling time. The capacitor array and the comparator are outside the block.

Top module: `adc_op_sequencer`

## Requirements
- R1: An operation begins only when `osc_en`, `cfg_en` and `cfg_go` are all 1. While `osc_en` is 0 the converter stays unpowered (`adc_pwr` = 0) and `eoc` never rises.
- R2: An operation that starts without a warm converter first waits `(1000 - 200*start_sel)` microseconds, counted as `TICKS_PER_US` ticks each. So 00 means 1000 µs, 01 means 800 µs, 10 means 600 µs and 11 means 400 µs.
- R3: One conversion-clock period is 2^`clk_sel` ticks, and `eoc` stays high for exactly one such period.
- R4: After the settling wait, the operation takes exactly 15 conversion-clock periods before `eoc` rises.
- R5: `clr_ctrl` pulses for a single cycle in the cycle in which `eoc` rises. `eoc` rises once per operation.
- R6: With `succ_mode` = 1 the converter stays powered after the operation, and the next operation starts its 15 periods without a settling wait. With `succ_mode` = 0, `adc_pwr` drops when `eoc` ends.
- R7: In conversion mode (`cfg_mode` = 0) the DAC trial code is built MSB first. A bit is kept when `cmp_in` = 1, meaning the input is above the trial. The final code is written through `res_we`/`res_data`. With `range_sel` = 0 the code is unsigned, 0 to 4095.
- R8: With `range_sel` = 1, a result is sign-magnitude: bit 11 is the sign (1 = negative) and bits 10:0 are the magnitude of (code - 2048). Code 0 saturates to -2047 (0xFFF), and 0x800 is never written.
- R9: In comparison mode (`cfg_mode` = 1), `res_we` stays 0. `rslt_we` pulses and `rslt_val` carries `cmp_in` as seen at the final period, with the threshold held on the DAC.
- R10: The threshold is `data_reg`. When `range_sel` = 1 it is read as sign-magnitude, and the DAC level is 2048 + magnitude for a positive sign or 2048 - magnitude for a negative one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase strobe, `TICKS_PER_US` per microsecond |
| osc_en | input | 1 | Oscillator enable; gates any start |
| cfg_en | input | 1 | Converter enable bit |
| cfg_go | input | 1 | Start/stop bit |
| cfg_mode | input | 1 | 0 = conversion, 1 = comparison |
| range_sel | input | 1 | 0 = unsigned, 1 = sign-magnitude |
| clk_sel | input | 3 | Conversion clock divider exponent |
| start_sel | input | 2 | Settling time select |
| succ_mode | input | 1 | Keep the converter powered between operations |
| data_reg | input | 12 | Data register contents (threshold in comparison mode) |
| cmp_in | input | 1 | Comparator: 1 when input is above the DAC level |
| dac_code | output | 12 | DAC trial code (offset binary) |
| res_we | output | 1 | Write strobe for the data register |
| res_data | output | 12 | Conversion result |
| rslt_we | output | 1 | Write strobe for the comparison flag |
| rslt_val | output | 1 | Comparison outcome |
| clr_ctrl | output | 1 | Request to clear the enable and start bits |
| eoc | output | 1 | End-of-operation flag, one conversion period wide |
| adc_pwr | output | 1 | Converter power request |

## Verification
The assertions assume that the register file acts on `clr_ctrl` and drops `cfg_en` and `cfg_go` before the end flag ends. They also assume that mode, range, divider and threshold are left untouched while an operation runs. The bench complies: it clears both bits on the cycle it sees the clear strobe, and it changes configuration only while the block is idle. The comparator model compares against half-LSB offsets, so the input never equals a trial level and no result depends on a tie.

// File: rtl/adc_seq_pkg.sv
// Shared definitions for the conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package adc_seq_pkg;

    // Control phases of one operation.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WARM = 2'd1,
        SEQ_RUN  = 2'd2,
        SEQ_DONE = 2'd3
    } seq_state_t;

    localparam int SEQ_DATA_W  = 12;
    localparam int SEQ_OP_CYC  = 15;
    localparam int SEQ_SEL_W   = 3;
    localparam int SEQ_START_W = 2;

endpackage

// File: rtl/adc_conv_clk.sv
// Conversion clock strobe generator.
// Counts timebase ticks while the sequencer runs and emits one strobe
// every 2**sel ticks. The prescaler restarts at zero on every run, so the
// first strobe lands exactly one full period after the run begins.
// Assumes: sel is stable while run is high.
module adc_conv_clk #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             stb
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] mask;

    // Low-bit mask whose all-ones state marks the end of a period.
    always_comb begin
        mask = PRE_W'((32'd1 << sel) - 32'd1);
    end

    // Prescaler: counts ticks during a run, parked at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!run) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assign stb = run && tick && ((pre_cnt & mask) == mask);

endmodule

// File: rtl/adc_startup_timer.sv
// Settling-time counter for a cold converter.
// Loaded with (BASE_US - STEP_US*code) microseconds of ticks, then counts
// down on ticks while enabled; done marks the tick that ends the wait.
// Assumes: load and count_en are never high together.
module adc_startup_timer #(
    parameter int START_W      = 2,
    parameter int TICKS_PER_US = 1,
    parameter int BASE_US      = 1000,
    parameter int STEP_US      = 200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [START_W-1:0] code,
    input  logic               count_en,
    input  logic               tick,
    output logic               done
);
    localparam int MAX_TICKS = BASE_US * TICKS_PER_US;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] load_val;

    // Settling length in ticks for the selected code.
    always_comb begin
        load_val = CNT_W'((BASE_US - STEP_US * int'(code)) * TICKS_PER_US);
    end

    // Down-counter of remaining ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (count_en && tick && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = count_en && tick && (remain <= CNT_W'(1));

endmodule

// File: rtl/sar_step_engine.sv
// Step counter and trial register for one operation.
// Step 0 loads the trial (MSB alone for conversion, threshold for
// comparison). Steps 1..DATA_W each settle one bit, MSB first, from the
// comparator and raise the next lower bit. The remaining steps are idle
// finalize periods; last marks the strobe of step OP_CYCLES-1.
// Assumes: OP_CYCLES > DATA_W + 1 and the comparator is valid at each strobe.
module sar_step_engine #(
    parameter int DATA_W    = 12,
    parameter int OP_CYCLES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              stb,
    input  logic              cmp_mode,
    input  logic [DATA_W-1:0] thr_code,
    input  logic              cmp_in,
    output logic [DATA_W-1:0] trial,
    output logic              last
);
    localparam int STEP_W = $clog2(OP_CYCLES);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(OP_CYCLES - 1);
    localparam logic [DATA_W-1:0] MSB_ONLY  = DATA_W'(1) << (DATA_W - 1);

    logic [STEP_W-1:0] step;
    int                cur_bit;

    // Bit under test at the current step.
    always_comb begin
        cur_bit = DATA_W - int'(step);
    end

    // Step counter: restarts whenever the sequencer leaves the run phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            step <= '0;
        end else if (stb && (step != LAST_STEP)) begin
            step <= step + 1'b1;
        end
    end

    // Trial register: one bit per strobe. Each bit position is a copy of
    // the same decision slice.
    generate
        for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    trial[gi] <= 1'b0;
                end else if (active && stb) begin
                    if (step == '0) begin
                        trial[gi] <= cmp_mode ? thr_code[gi] : MSB_ONLY[gi];
                    end else if (!cmp_mode && (int'(step) <= DATA_W)) begin
                        if (gi == cur_bit) begin
                            trial[gi] <= trial[gi] & cmp_in;
                        end else if (gi == cur_bit - 1) begin
                            trial[gi] <= 1'b1;
                        end
                    end
                end
            end
        end
    endgenerate

    assign last = active && stb && (step == LAST_STEP);

endmodule

// File: rtl/code_xlate.sv
// Translation between offset-binary DAC codes and sign-magnitude words.
// Offset binary 0 maps to the most negative magnitude available (all
// ones), so the sign-magnitude negative zero is never produced.
// Assumes: DATA_W >= 2.
module code_xlate #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] ob_in,
    input  logic [DATA_W-1:0] sm_in,
    output logic [DATA_W-1:0] sm_out,
    output logic [DATA_W-1:0] ob_out
);
    localparam int MAG_W = DATA_W - 1;
    localparam logic [DATA_W-1:0] HALF = DATA_W'(1) << MAG_W;

    logic [DATA_W-1:0] neg_mag;
    logic [DATA_W-1:0] sm_mag;

    // Offset binary to sign-magnitude, saturating the bottom code.
    always_comb begin
        neg_mag = HALF - ob_in;
        if (ob_in[DATA_W-1]) begin
            sm_out = {1'b0, ob_in[MAG_W-1:0]};
        end else if (ob_in == '0) begin
            sm_out = '1;
        end else begin
            sm_out = {1'b1, neg_mag[MAG_W-1:0]};
        end
    end

    // Sign-magnitude to offset binary around mid-scale.
    always_comb begin
        sm_mag = {1'b0, sm_in[MAG_W-1:0]};
        ob_out = sm_in[DATA_W-1] ? (HALF - sm_mag) : (HALF + sm_mag);
    end

endmodule

// File: rtl/adc_op_sequencer.sv
// Top of the conversion/comparison sequencer.
// Sequences idle -> settle -> 15-period run -> end flag, powers the
// converter, and writes results back through one-cycle strobes.
// Assumes: the register file clears cfg_en/cfg_go on clr_ctrl before eoc
// falls, and configuration is unchanged while an operation runs.
module adc_op_sequencer
    import adc_seq_pkg::*;
#(
    parameter int DATA_W       = SEQ_DATA_W,
    parameter int OP_CYCLES    = SEQ_OP_CYC,
    parameter int SEL_W        = SEQ_SEL_W,
    parameter int START_W      = SEQ_START_W,
    parameter int TICKS_PER_US = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               osc_en,
    input  logic               cfg_en,
    input  logic               cfg_go,
    input  logic               cfg_mode,
    input  logic               range_sel,
    input  logic [SEL_W-1:0]   clk_sel,
    input  logic [START_W-1:0] start_sel,
    input  logic               succ_mode,
    input  logic [DATA_W-1:0]  data_reg,
    input  logic               cmp_in,
    output logic [DATA_W-1:0]  dac_code,
    output logic               res_we,
    output logic [DATA_W-1:0]  res_data,
    output logic               rslt_we,
    output logic               rslt_val,
    output logic               clr_ctrl,
    output logic               eoc,
    output logic               adc_pwr
);
    seq_state_t        state;
    logic              warm;
    logic              op_mode;
    logic              op_range;
    logic              start_req;
    logic              cold_start;
    logic              conv_stb;
    logic              settle_done;
    logic              step_last;
    logic              in_run;
    logic [DATA_W-1:0] trial;
    logic [DATA_W-1:0] trial_sm;
    logic [DATA_W-1:0] thr_ob;
    logic [DATA_W-1:0] thr_code;

    // Start request and whether it must pay the settling time.
    always_comb begin
        start_req  = (state == SEQ_IDLE) && osc_en && cfg_en && cfg_go;
        cold_start = start_req && !(warm && succ_mode);
        in_run     = (state == SEQ_RUN);
        thr_code   = op_range ? thr_ob : data_reg;
    end

    adc_conv_clk #(
        .SEL_W (SEL_W)
    ) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((state == SEQ_RUN) || (state == SEQ_DONE)),
        .tick  (tick),
        .sel   (clk_sel),
        .stb   (conv_stb)
    );

    adc_startup_timer #(
        .START_W      (START_W),
        .TICKS_PER_US (TICKS_PER_US)
    ) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cold_start),
        .code     (start_sel),
        .count_en (state == SEQ_WARM),
        .tick     (tick),
        .done     (settle_done)
    );

    sar_step_engine #(
        .DATA_W    (DATA_W),
        .OP_CYCLES (OP_CYCLES)
    ) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (in_run),
        .stb      (conv_stb),
        .cmp_mode (op_mode),
        .thr_code (thr_code),
        .cmp_in   (cmp_in),
        .trial    (trial),
        .last     (step_last)
    );

    code_xlate #(
        .DATA_W (DATA_W)
    ) u_xlate (
        .ob_in  (trial),
        .sm_in  (data_reg),
        .sm_out (trial_sm),
        .ob_out (thr_ob)
    );

    // Phase sequencing, power control and result write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            warm     <= 1'b0;
            adc_pwr  <= 1'b0;
            op_mode  <= 1'b0;
            op_range <= 1'b0;
            res_we   <= 1'b0;
            res_data <= '0;
            rslt_we  <= 1'b0;
            rslt_val <= 1'b0;
            clr_ctrl <= 1'b0;
        end else begin
            res_we   <= 1'b0;
            rslt_we  <= 1'b0;
            clr_ctrl <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (!osc_en || !succ_mode) begin
                        warm    <= 1'b0;
                        adc_pwr <= 1'b0;
                    end
                    if (start_req) begin
                        adc_pwr  <= 1'b1;
                        op_mode  <= cfg_mode;
                        op_range <= range_sel;
                        state    <= cold_start ? SEQ_WARM : SEQ_RUN;
                    end
                end
                SEQ_WARM: begin
                    if (settle_done) begin
                        state <= SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (step_last) begin
                        state    <= SEQ_DONE;
                        clr_ctrl <= 1'b1;
                        warm     <= succ_mode;
                        if (op_mode) begin
                            rslt_we  <= 1'b1;
                            rslt_val <= cmp_in;
                        end else begin
                            res_we   <= 1'b1;
                            res_data <= op_range ? trial_sm : trial;
                        end
                    end
                end
                SEQ_DONE: begin
                    if (conv_stb) begin
                        state <= SEQ_IDLE;
                        if (!succ_mode) begin
                            adc_pwr <= 1'b0;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign eoc      = (state == SEQ_DONE);
    assign dac_code = trial;

endmodule

// File: rtl/adc_op_sequencer_chk.sv
// Property checker for the sequencer, attached by bind below.
// Assumes: the reset is synchronous and active low.
module adc_op_sequencer_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              osc_en,
    input logic              eoc,
    input logic              clr_ctrl,
    input logic              res_we,
    input logic              rslt_we,
    input logic [DATA_W-1:0] res_data,
    input logic              op_range,
    input logic              adc_pwr
);
    localparam logic [DATA_W-1:0] NEG_ZERO = DATA_W'(1) << (DATA_W - 1);

    // R1: no power comes up while the oscillator is off.
    p_no_power_without_osc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !adc_pwr) |=> !adc_pwr);

    // R5: the clear request accompanies the rise of the end flag.
    p_clear_at_eoc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc) |-> clr_ctrl);

    // R5: the clear request lasts a single cycle.
    p_clear_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ctrl |=> !clr_ctrl);

    // R6: the converter is powered for the whole end flag.
    p_eoc_powered_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> adc_pwr);

    // R7: result writes happen only as the operation ends.
    p_write_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> $rose(eoc));

    // R8: sign-magnitude results never carry negative zero.
    p_no_neg_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && op_range) |-> (res_data != NEG_ZERO));

    // R9: one kind of write per operation.
    p_one_write_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_we, rslt_we}));

endmodule

bind adc_op_sequencer adc_op_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .eoc      (eoc),
    .clr_ctrl (clr_ctrl),
    .res_we   (res_we),
    .rslt_we  (rslt_we),
    .res_data (res_data),
    .op_range (op_range),
    .adc_pwr  (adc_pwr)
);

// File: tb/adc_op_sequencer_tb.sv
// Bench: directed corners plus seeded random operations, with a
// behavioural comparator that uses half-LSB input levels.
module adc_op_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        osc_en = 1'b0;
    logic        cfg_en = 1'b0;
    logic        cfg_go = 1'b0;
    logic        cfg_mode = 1'b0;
    logic        range_sel = 1'b0;
    logic [2:0]  clk_sel = 3'd0;
    logic [1:0]  start_sel = 2'd0;
    logic        succ_mode = 1'b0;
    logic [11:0] data_reg = 12'd0;
    logic        cmp_in;
    logic [11:0] dac_code;
    logic        res_we, rslt_we, rslt_val, clr_ctrl, eoc, adc_pwr;
    logic [11:0] res_data;

    int  a2 = 1;
    int  n_checks = 0;
    int  n_fails = 0;
    bit  warm_b = 1'b0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    assign cmp_in = (a2 > 2 * int'(dac_code));

    adc_op_sequencer u_dut (
        .clk (clk), .rst_n (rst_n), .tick (tick), .osc_en (osc_en),
        .cfg_en (cfg_en), .cfg_go (cfg_go), .cfg_mode (cfg_mode),
        .range_sel (range_sel), .clk_sel (clk_sel), .start_sel (start_sel),
        .succ_mode (succ_mode), .data_reg (data_reg), .cmp_in (cmp_in),
        .dac_code (dac_code), .res_we (res_we), .res_data (res_data),
        .rslt_we (rslt_we), .rslt_val (rslt_val), .clr_ctrl (clr_ctrl),
        .eoc (eoc), .adc_pwr (adc_pwr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_conv(input int v, input bit rng);
        if (!rng) return 12'(v);
        if (v >= 2048) return 12'(v - 2048);
        if (v == 0) return 12'hFFF;
        return {1'b1, 11'(2048 - v)};
    endfunction

    function automatic int thr_level(input logic [11:0] t, input bit rng);
        if (!rng) return int'(t);
        return t[11] ? 2048 - int'(t[10:0]) : 2048 + int'(t[10:0]);
    endfunction

    // One full operation with timing and result checks.
    task automatic run_op(input bit md, input bit rng, input logic [2:0] cs,
                          input logic [1:0] ss, input bit succ, input int v,
                          input logic [11:0] thr);
        int  lat_exp, cyc, width;
        bit  got_res, got_rslt, got_clr, rv;
        logic [11:0] rd;
        bit  skip;
        skip = warm_b && succ;
        lat_exp = (skip ? 0 : (1000 - 200 * int'(ss))) + 15 * (1 << cs) + 1;
        @(negedge clk);
        cfg_mode = md; range_sel = rng; clk_sel = cs; start_sel = ss;
        succ_mode = succ; osc_en = 1'b1; a2 = 2 * v + 1;
        if (md) data_reg = thr;
        cfg_en = 1'b1; cfg_go = 1'b1;
        cyc = 0; got_res = 0; got_rslt = 0; got_clr = 0; rv = 0; rd = '0;
        while (!eoc && cyc < lat_exp + 40) begin
            @(negedge clk);
            cyc++;
            if (res_we) begin got_res = 1; rd = res_data; data_reg = res_data; end
            if (rslt_we) begin got_rslt = 1; rv = rslt_val; end
            if (clr_ctrl) begin got_clr = 1; cfg_en = 1'b0; cfg_go = 1'b0; end
        end
        check(cyc == lat_exp, "R2/R4", "latency", cyc, lat_exp);
        check(got_clr, "R5", "clear pulse with eoc", int'(got_clr), 1);
        width = 0;
        while (eoc && width < 300) begin
            width++;
            @(negedge clk);
            if (clr_ctrl) check(0, "R5", "extra clear pulse", 1, 0);
        end
        check(width == (1 << cs), "R3", "eoc width", width, 1 << cs);
        check(adc_pwr == succ, "R6", "power after op", int'(adc_pwr), int'(succ));
        if (md) begin
            check(!got_res, "R9", "no data write in comparison", int'(got_res), 0);
            check(got_rslt && (rv == (a2 > 2 * thr_level(thr, rng))),
                  rng ? "R10" : "R9", "comparison flag", int'(rv),
                  int'(a2 > 2 * thr_level(thr, rng)));
        end else begin
            check(got_res && (rd == exp_conv(v, rng)), rng ? "R8" : "R7",
                  "conversion result", int'(rd), int'(exp_conv(v, rng)));
        end
        warm_b = succ;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!eoc && !adc_pwr && !clr_ctrl && !res_we && !rslt_we, "R5",
              "reset state", int'({eoc, adc_pwr, clr_ctrl, res_we, rslt_we}), 0);

        // R1: start bits set with the oscillator off must not start anything.
        osc_en = 1'b0; cfg_en = 1'b1; cfg_go = 1'b1;
        begin
            bit seen = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (eoc || adc_pwr) seen = 1;
            end
            check(!seen, "R1", "activity with oscillator off", int'(seen), 0);
        end
        cfg_en = 1'b0; cfg_go = 1'b0;
        @(negedge clk);

        // Directed corners.
        run_op(0, 0, 3'd0, 2'd0, 0, 4095, 12'd0);   // R7 top code
        run_op(0, 1, 3'd1, 2'd1, 0, 0,    12'd0);   // R8 saturation
        run_op(0, 1, 3'd0, 2'd3, 0, 2048, 12'd0);   // R8 zero
        run_op(0, 0, 3'd7, 2'd2, 1, 1234, 12'd0);   // R3 slowest clock
        run_op(0, 1, 3'd2, 2'd0, 1, 3000, 12'd0);   // R6 skip settling
        run_op(1, 0, 3'd1, 2'd0, 1, 1000, 12'd1000);// R9 just above
        run_op(1, 0, 3'd0, 2'd0, 0, 999,  12'd1000);// R9 just below
        run_op(1, 1, 3'd0, 2'd3, 0, 2043, 12'h805); // R10 negative threshold
        run_op(1, 1, 3'd0, 2'd3, 0, 2042, 12'h805); // R10 below it
        run_op(1, 1, 3'd1, 2'd2, 0, 2100, 12'h032); // R10 positive threshold

        // Seeded random operations.
        void'($urandom(32'd7215));
        for (int k = 0; k < 16; k++) begin
            bit          md   = 1'($urandom_range(0, 1));
            bit          rng  = 1'($urandom_range(0, 1));
            logic [2:0]  cs   = 3'($urandom_range(0, 3));
            logic [1:0]  ss   = 2'($urandom_range(0, 3));
            bit          succ = 1'($urandom_range(0, 1));
            int          v    = int'($urandom_range(0, 4095));
            logic [11:0] thr  = 12'($urandom_range(0, 4095));
            run_op(md, rng, cs, ss, succ, v, thr);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

endmodule